// File: doc/BRIEF.md
# Retired Store Queue Pair with Load Forwarding

This block holds stores in the gap between retirement in a speculative core and the final write of those stores by an in-order verifier that checks the core. It has two ring buffers. The core-side ring accepts each store (word address, data, byte enables) at the moment the store leaves the core for checking. This lets the core free its own load/store tracking entry at once. Entries in the core-side ring never reach the cache. An entry is dropped from the head when the verifier commits the matching store, and the whole ring is cleared when the verifier declares a fault.

While a store sits in the core-side ring, a core load probes the ring in the same cycle as the L1 lookup. If one or more held stores target the loaded word and write at least one requested byte, the youngest such store supplies its bytes in place of the cache bytes. A partial flag warns that this store did not cover every requested byte.

The checker-side ring takes stores that the verifier has already checked. It writes its oldest entry to the L1 cache in any cycle in which a cache write port is free. Each ring holds a parameterised number of entries, eight by default, and that number must be a power of two. When a ring is full, its ready output drops and the feeding stage stalls. The exception is a cycle in which the head entry leaves, because the freed slot can take the new store in that same cycle.

Top module: `rsq_pair`

## Requirements
- R1: After reset both rings are empty. `core_st_ready` and `ver_st_ready` are 1, `ld_fwd_hit` and `ld_fwd_partial` are 0, `ld_rdata` equals `l1_rdata`, and `l1_wr_valid` is 0.
- R2: The core-side ring stores a store on a rising edge when `core_st_valid` and `core_st_ready` are both 1. With 8 entries held and `chk_commit` at 0, `core_st_ready` is 0 and the offered store is dropped, so a later probe of its address misses.
- R3: With 8 entries held, `core_st_ready` is 1 while `chk_commit` is 1. A store and a release in that same cycle both take effect: the new store then forwards and the ring is still full.
- R4: A probe hits when a held core-side entry has a word address equal to `ld_addr` and a byte mask that shares at least one bit with `ld_mask`. Bit b of a mask enables data bits [8b+7:8b]. On a hit, each byte the entry's mask enables comes from the entry and every other byte comes from `l1_rdata`. On a miss, `ld_rdata` equals `l1_rdata`.
- R5: When several held entries qualify under R4, only the most recently stored one supplies data. A younger entry with the same address but no byte overlap with `ld_mask` does not qualify.
- R6: `ld_fwd_partial` is 1 exactly when `ld_fwd_hit` is 1 and `ld_mask` requests a byte that the supplying entry's mask does not enable.
- R7: A rising edge with `chk_commit` at 1 frees the oldest core-side entry, which then no longer forwards. `chk_commit` on an empty ring has no effect.
- R8: A rising edge with `chk_fault` at 1 empties the core-side ring. A store or release offered in that cycle is discarded, and in the next cycle no probe hits and `core_st_ready` is 1.
- R9: The checker-side ring presents its oldest entry on `l1_wr_addr`, `l1_wr_data` and `l1_wr_mask`. `l1_wr_valid` is 1 exactly when that ring is non-empty and `l1_wr_free` is 1, and the entry leaves on that edge. Entries leave in arrival order, and the head is held unchanged while `l1_wr_free` is 0.
- R10: With 8 checker-side entries held, `ver_st_ready` is 0 while `l1_wr_free` is 0 and 1 while it is 1. A store offered in a write cycle enters, and a store offered while not ready is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_st_valid | input | 1 | Retired core store offered |
| core_st_addr | input | 30 | Word address of the retired store |
| core_st_data | input | 32 | Data of the retired store |
| core_st_mask | input | 4 | Byte enables of the retired store |
| core_st_ready | output | 1 | Core-side ring can take a store this cycle |
| chk_commit | input | 1 | Verifier committed the oldest store; free the core-side head |
| chk_fault | input | 1 | Verifier declared a fault; empty the core-side ring |
| ld_addr | input | 30 | Word address of the core load probe |
| ld_mask | input | 4 | Requested bytes of the load |
| l1_rdata | input | 32 | Data read from the L1 cache in parallel |
| ld_rdata | output | 32 | Load data after forwarding |
| ld_fwd_hit | output | 1 | A held store supplied bytes |
| ld_fwd_partial | output | 1 | The supplying store misses some requested byte |
| ver_st_valid | input | 1 | Verified store offered |
| ver_st_addr | input | 30 | Word address of the verified store |
| ver_st_data | input | 32 | Data of the verified store |
| ver_st_mask | input | 4 | Byte enables of the verified store |
| ver_st_ready | output | 1 | Checker-side ring can take a store this cycle |
| l1_wr_free | input | 1 | An L1 write port is free this cycle |
| l1_wr_valid | output | 1 | Cache write of the checker-side head this cycle |
| l1_wr_addr | output | 30 | Word address of the cache write |
| l1_wr_data | output | 32 | Data of the cache write |
| l1_wr_mask | output | 4 | Byte enables of the cache write |

## Verification
The bench loads stores that target the same word with disjoint and overlapping masks. This exposes a forwarder that takes the oldest match, or that lets a younger entry with no byte overlap win; either error returns the wrong bytes or a wrong partial flag. It offers a store while the ring is full, once with a release in the same cycle and once without. A design that drops the same-cycle store, or that accepts a store into a full ring, then forwards the wrong addresses. It applies a fault together with a new store, and a release to an empty ring, to catch stale entries after a flush and pointers that drift on underflow. On the checker side it holds the write port busy and then frees it, which catches writes out of order, a head that moves while the port is busy, and a ready signal that ignores the write freeing a slot.

// File: rtl/rsq_pkg.sv
`timescale 1ns/1ps
package rsq_pkg;
  parameter int unsigned RSQ_AW = 30;
  parameter int unsigned RSQ_DW = 32;
  localparam int unsigned RSQ_BW = RSQ_DW / 8;

  typedef struct packed {
    logic [RSQ_AW-1:0] addr;
    logic [RSQ_DW-1:0] data;
    logic [RSQ_BW-1:0] mask;
  } rsq_ent_t;

  // replace the bytes of base selected by sel with those of over
  function automatic logic [RSQ_DW-1:0] rsq_byte_merge(
    input logic [RSQ_DW-1:0] base,
    input logic [RSQ_DW-1:0] over,
    input logic [RSQ_BW-1:0] sel
  );
    logic [RSQ_DW-1:0] r;
    r = base;
    for (int b = 0; b < int'(RSQ_BW); b++) begin
      if (sel[b]) r[b*8 +: 8] = over[b*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic rsq_overlap(input logic [RSQ_BW-1:0] a,
                                       input logic [RSQ_BW-1:0] b);
    return |(a & b);
  endfunction

  // every requested byte is enabled by the entry mask
  function automatic logic rsq_covers(input logic [RSQ_BW-1:0] ent_mask,
                                      input logic [RSQ_BW-1:0] req);
    return (req & ~ent_mask) == '0;
  endfunction
endpackage

// File: rtl/rsq_ring.sv
`timescale 1ns/1ps
module rsq_ring #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic                       clear,
  output logic [$clog2(DEPTH)-1:0]   wr_idx,
  output logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= wr_idx + 1'b1;
      if (pop)  rd_idx <= rd_idx + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  // R2 / R10: the owner never pushes into a full ring unless the head leaves
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear) |-> (!full || pop));

  // R7: the head is never freed from an empty ring
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R8: a clear leaves the ring empty on the next cycle
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);
endmodule

// File: rtl/rsq_fwd.sv
`timescale 1ns/1ps
module rsq_fwd
  import rsq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  rsq_ent_t [DEPTH-1:0]       ents,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  input  logic [$clog2(DEPTH):0]     count,
  input  logic [RSQ_AW-1:0]          ld_addr,
  input  logic [RSQ_BW-1:0]          ld_mask,
  input  logic [RSQ_DW-1:0]          cache_data,
  output logic [RSQ_DW-1:0]          ld_data,
  output logic                       ld_hit,
  output logic                       ld_partial
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic              found;
  rsq_ent_t          pick;
  logic [PW-1:0]     idx;

  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      idx = rd_idx + PW'(i);
      if ((CW'(i) < count) && (ents[idx].addr == ld_addr) &&
          rsq_overlap(ents[idx].mask, ld_mask)) begin
        found = 1'b1;
        pick  = ents[idx];
      end
    end
  end

  assign ld_hit     = found;
  assign ld_partial = found && !rsq_covers(pick.mask, ld_mask);
  assign ld_data    = found ? rsq_byte_merge(cache_data, pick.data, pick.mask)
                            : cache_data;
endmodule

// File: rtl/rsq_core_q.sv
`timescale 1ns/1ps
module rsq_core_q
  import rsq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enq_valid,
  input  rsq_ent_t           enq_ent,
  output logic               enq_ready,
  input  logic               rel,
  input  logic               flush,
  input  logic [RSQ_AW-1:0]  ld_addr,
  input  logic [RSQ_BW-1:0]  ld_mask,
  input  logic [RSQ_DW-1:0]  cache_data,
  output logic [RSQ_DW-1:0]  ld_data,
  output logic               ld_hit,
  output logic               ld_partial
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic                  push_evt;
  logic                  pop_evt;
  logic                  ring_full;
  logic                  ring_empty;
  logic [PW-1:0]         wr_idx;
  logic [PW-1:0]         rd_idx;
  logic [CW-1:0]         count;
  rsq_ent_t [DEPTH-1:0]  slots;

  // a release frees the head slot in the same cycle, so a full ring still accepts
  assign enq_ready = !ring_full || rel;
  assign push_evt  = enq_valid && enq_ready && !flush;
  assign pop_evt   = rel && !ring_empty && !flush;

  rsq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push_evt),
    .pop    (pop_evt),
    .clear  (flush),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .count  (count),
    .full   (ring_full),
    .empty  (ring_empty)
  );

  always_ff @(posedge clk) begin
    if (push_evt) slots[wr_idx] <= enq_ent;
  end

  rsq_fwd #(.DEPTH(DEPTH)) u_fwd (
    .ents       (slots),
    .rd_idx     (rd_idx),
    .count      (count),
    .ld_addr    (ld_addr),
    .ld_mask    (ld_mask),
    .cache_data (cache_data),
    .ld_data    (ld_data),
    .ld_hit     (ld_hit),
    .ld_partial (ld_partial)
  );

  // R8: after a fault nothing is left to forward
  assert_flush_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ld_hit);

  // R3: store plus release on a full ring keeps it full
  assert_full_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_full && push_evt && pop_evt) |=> ring_full);
endmodule

// File: rtl/rsq_drain_q.sv
`timescale 1ns/1ps
module rsq_drain_q
  import rsq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enq_valid,
  input  rsq_ent_t  enq_ent,
  output logic      enq_ready,
  input  logic      port_free,
  output logic      wr_valid,
  output rsq_ent_t  wr_ent
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic                  push_evt;
  logic                  pop_evt;
  logic                  ring_full;
  logic                  ring_empty;
  logic [PW-1:0]         wr_idx;
  logic [PW-1:0]         rd_idx;
  logic [CW-1:0]         count;
  rsq_ent_t [DEPTH-1:0]  slots;

  assign pop_evt   = port_free && !ring_empty;
  assign enq_ready = !ring_full || pop_evt;
  assign push_evt  = enq_valid && enq_ready;
  assign wr_valid  = pop_evt;
  assign wr_ent    = slots[rd_idx];

  rsq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push_evt),
    .pop    (pop_evt),
    .clear  (1'b0),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .count  (count),
    .full   (ring_full),
    .empty  (ring_empty)
  );

  always_ff @(posedge clk) begin
    if (push_evt) slots[wr_idx] <= enq_ent;
  end

  // R10: full ring with a busy port stalls the feeding stage
  assert_stall_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_full && !port_free) |-> !enq_ready);

  // R9: the head waits unchanged while no write port is free
  assert_head_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring_empty && !port_free) |=> $stable(wr_ent));
endmodule

// File: rtl/rsq_pair.sv
`timescale 1ns/1ps
module rsq_pair
  import rsq_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_st_valid,
  input  logic [RSQ_AW-1:0]  core_st_addr,
  input  logic [RSQ_DW-1:0]  core_st_data,
  input  logic [RSQ_BW-1:0]  core_st_mask,
  output logic               core_st_ready,
  input  logic               chk_commit,
  input  logic               chk_fault,
  input  logic [RSQ_AW-1:0]  ld_addr,
  input  logic [RSQ_BW-1:0]  ld_mask,
  input  logic [RSQ_DW-1:0]  l1_rdata,
  output logic [RSQ_DW-1:0]  ld_rdata,
  output logic               ld_fwd_hit,
  output logic               ld_fwd_partial,
  input  logic               ver_st_valid,
  input  logic [RSQ_AW-1:0]  ver_st_addr,
  input  logic [RSQ_DW-1:0]  ver_st_data,
  input  logic [RSQ_BW-1:0]  ver_st_mask,
  output logic               ver_st_ready,
  input  logic               l1_wr_free,
  output logic               l1_wr_valid,
  output logic [RSQ_AW-1:0]  l1_wr_addr,
  output logic [RSQ_DW-1:0]  l1_wr_data,
  output logic [RSQ_BW-1:0]  l1_wr_mask
);
  rsq_ent_t core_ent;
  rsq_ent_t ver_ent;
  rsq_ent_t drain_ent;

  assign core_ent = '{addr: core_st_addr, data: core_st_data, mask: core_st_mask};
  assign ver_ent  = '{addr: ver_st_addr,  data: ver_st_data,  mask: ver_st_mask};

  rsq_core_q #(.DEPTH(DEPTH)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_valid  (core_st_valid),
    .enq_ent    (core_ent),
    .enq_ready  (core_st_ready),
    .rel        (chk_commit),
    .flush      (chk_fault),
    .ld_addr    (ld_addr),
    .ld_mask    (ld_mask),
    .cache_data (l1_rdata),
    .ld_data    (ld_rdata),
    .ld_hit     (ld_fwd_hit),
    .ld_partial (ld_fwd_partial)
  );

  rsq_drain_q #(.DEPTH(DEPTH)) u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (ver_st_valid),
    .enq_ent   (ver_ent),
    .enq_ready (ver_st_ready),
    .port_free (l1_wr_free),
    .wr_valid  (l1_wr_valid),
    .wr_ent    (drain_ent)
  );

  assign l1_wr_addr = drain_ent.addr;
  assign l1_wr_data = drain_ent.data;
  assign l1_wr_mask = drain_ent.mask;

  // R6: a partial hit is always a hit
  assert_partial_needs_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fwd_partial |-> ld_fwd_hit);
endmodule

// File: tb/sim_rsq_pair.sv
`timescale 1ns/1ps
module sim_rsq_pair;
  import rsq_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               core_st_valid = 1'b0;
  logic [RSQ_AW-1:0]  core_st_addr = '0;
  logic [RSQ_DW-1:0]  core_st_data = '0;
  logic [RSQ_BW-1:0]  core_st_mask = '0;
  logic               core_st_ready;
  logic               chk_commit = 1'b0;
  logic               chk_fault = 1'b0;
  logic [RSQ_AW-1:0]  ld_addr = '0;
  logic [RSQ_BW-1:0]  ld_mask = '0;
  logic [RSQ_DW-1:0]  l1_rdata = '0;
  logic [RSQ_DW-1:0]  ld_rdata;
  logic               ld_fwd_hit;
  logic               ld_fwd_partial;
  logic               ver_st_valid = 1'b0;
  logic [RSQ_AW-1:0]  ver_st_addr = '0;
  logic [RSQ_DW-1:0]  ver_st_data = '0;
  logic [RSQ_BW-1:0]  ver_st_mask = '0;
  logic               ver_st_ready;
  logic               l1_wr_free = 1'b0;
  logic               l1_wr_valid;
  logic [RSQ_AW-1:0]  l1_wr_addr;
  logic [RSQ_DW-1:0]  l1_wr_data;
  logic [RSQ_BW-1:0]  l1_wr_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rsq_pair u0 (.*);

  // probe vectors: address, mask, cache data, expected data, hit, partial
  localparam int NV = 6;
  localparam logic [29:0] V_ADDR [NV] = '{30'h10, 30'h10, 30'h20, 30'h20, 30'h40, 30'h30};
  localparam logic [3:0]  V_MASK [NV] = '{4'hF, 4'h3, 4'h1, 4'hF, 4'hF, 4'h4};
  localparam logic [31:0] V_L1   [NV] = '{32'hCCCCCCCC, 32'hCCCCCCCC, 32'hCCCCCCCC,
                                          32'hCCCCCCCC, 32'hDEADBEEF, 32'h01234567};
  localparam logic [31:0] V_DATA [NV] = '{32'h3333CCCC, 32'h11111111, 32'hCCCC2222,
                                          32'hCCCC2222, 32'hDEADBEEF, 32'h44444444};
  localparam logic        V_HIT  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic        V_PART [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic core_put(input logic [29:0] a, input logic [31:0] d, input logic [3:0] m);
    core_st_valid = 1'b1; core_st_addr = a; core_st_data = d; core_st_mask = m;
    @(negedge clk);
    core_st_valid = 1'b0;
  endtask

  task automatic ver_put(input logic [29:0] a, input logic [31:0] d, input logic [3:0] m);
    ver_st_valid = 1'b1; ver_st_addr = a; ver_st_data = d; ver_st_mask = m;
    @(negedge clk);
    ver_st_valid = 1'b0;
  endtask

  task automatic probe(input logic [29:0] a, input logic [3:0] m, input logic [31:0] c);
    ld_addr = a; ld_mask = m; l1_rdata = c;
    #1;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired before the bench completed");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    probe(30'h10, 4'hF, 32'h89ABCDEF);
    chk("R1", "core_st_ready", 64'(core_st_ready), 64'd1);
    chk("R1", "ver_st_ready", 64'(ver_st_ready), 64'd1);
    chk("R1", "ld_fwd_hit", 64'(ld_fwd_hit), 64'd0);
    chk("R1", "ld_fwd_partial", 64'(ld_fwd_partial), 64'd0);
    chk("R1", "ld_rdata", 64'(ld_rdata), 64'h89ABCDEF);
    chk("R1", "l1_wr_valid", 64'(l1_wr_valid), 64'd0);

    // forwarding table: R4 R5 R6
    @(negedge clk);
    core_put(30'h10, 32'h11111111, 4'hF);
    core_put(30'h20, 32'h22222222, 4'h3);
    core_put(30'h10, 32'h33333333, 4'hC);
    core_put(30'h30, 32'h44444444, 4'hF);
    for (int v = 0; v < NV; v++) begin
      probe(V_ADDR[v], V_MASK[v], V_L1[v]);
      chk("R4/R5", $sformatf("vec%0d ld_rdata", v), 64'(ld_rdata), 64'(V_DATA[v]));
      chk("R4", $sformatf("vec%0d ld_fwd_hit", v), 64'(ld_fwd_hit), 64'(V_HIT[v]));
      chk("R6", $sformatf("vec%0d ld_fwd_partial", v), 64'(ld_fwd_partial), 64'(V_PART[v]));
      @(negedge clk);
    end

    // R7: release frees the oldest entry
    chk_commit = 1'b1;
    @(negedge clk);
    chk_commit = 1'b0;
    probe(30'h10, 4'h3, 32'h0BADF00D);
    chk("R7", "oldest freed ld_fwd_hit", 64'(ld_fwd_hit), 64'd0);
    chk("R7", "oldest freed ld_rdata", 64'(ld_rdata), 64'h0BADF00D);

    // R2 / R3: fill to eight
    for (int k = 0; k < 5; k++) core_put(30'h100 + 30'(k), 32'hA0000000 + 32'(k), 4'hF);
    core_st_valid = 1'b1; core_st_addr = 30'h300; core_st_data = 32'h77777777; core_st_mask = 4'hF;
    #1;
    chk("R2", "full ring core_st_ready", 64'(core_st_ready), 64'd0);
    @(negedge clk);
    core_st_addr = 30'h200; core_st_data = 32'h99999999; chk_commit = 1'b1;
    #1;
    chk("R3", "full ring with release core_st_ready", 64'(core_st_ready), 64'd1);
    @(negedge clk);
    core_st_valid = 1'b0; chk_commit = 1'b0;
    #1;
    chk("R3", "still full core_st_ready", 64'(core_st_ready), 64'd0);
    probe(30'h200, 4'hF, 32'h0);
    chk("R3", "swapped store ld_rdata", 64'(ld_rdata), 64'h99999999);
    probe(30'h300, 4'hF, 32'h5);
    chk("R2", "dropped store ld_fwd_hit", 64'(ld_fwd_hit), 64'd0);
    probe(30'h20, 4'h1, 32'h6);
    chk("R7", "released second entry ld_fwd_hit", 64'(ld_fwd_hit), 64'd0);
    probe(30'h104, 4'hF, 32'h0);
    chk("R4", "queued fill entry ld_rdata", 64'(ld_rdata), 64'hA0000004);

    // R8: fault empties ring and drops a same-cycle store
    @(negedge clk);
    chk_fault = 1'b1;
    core_st_valid = 1'b1; core_st_addr = 30'h400; core_st_data = 32'h12121212; core_st_mask = 4'hF;
    @(negedge clk);
    chk_fault = 1'b0; core_st_valid = 1'b0;
    #1;
    chk("R8", "after fault core_st_ready", 64'(core_st_ready), 64'd1);
    probe(30'h200, 4'hF, 32'h0);
    chk("R8", "after fault old entry hit", 64'(ld_fwd_hit), 64'd0);
    probe(30'h400, 4'hF, 32'h0);
    chk("R8", "after fault same-cycle store hit", 64'(ld_fwd_hit), 64'd0);

    // R7: release on empty ring is ignored
    @(negedge clk);
    chk_commit = 1'b1;
    @(negedge clk);
    chk_commit = 1'b0;
    core_put(30'h600, 32'h5A5A5A5A, 4'hF);
    core_put(30'h601, 32'hA5A5A5A5, 4'hF);
    chk_commit = 1'b1;
    @(negedge clk);
    chk_commit = 1'b0;
    probe(30'h600, 4'hF, 32'h0);
    chk("R7", "empty release ignored, first freed", 64'(ld_fwd_hit), 64'd0);
    probe(30'h601, 4'hF, 32'h0);
    chk("R7", "empty release ignored, second held", 64'(ld_rdata), 64'hA5A5A5A5);

    // R9: drain in order, held while port busy
    @(negedge clk);
    l1_wr_free = 1'b0;
    ver_put(30'h700, 32'hD0D0D0D0, 4'h1);
    ver_put(30'h701, 32'hD1D1D1D1, 4'h2);
    ver_put(30'h702, 32'hD2D2D2D2, 4'h8);
    #1;
    chk("R9", "busy port l1_wr_valid", 64'(l1_wr_valid), 64'd0);
    @(negedge clk);
    l1_wr_free = 1'b1;
    #1;
    chk("R9", "first write valid", 64'(l1_wr_valid), 64'd1);
    chk("R9", "first write entry", {l1_wr_addr, l1_wr_data, l1_wr_mask},
        {30'h700, 32'hD0D0D0D0, 4'h1});
    @(negedge clk);
    #1;
    chk("R9", "second write entry", {l1_wr_addr, l1_wr_data, l1_wr_mask},
        {30'h701, 32'hD1D1D1D1, 4'h2});
    @(negedge clk);
    l1_wr_free = 1'b0;
    #1;
    chk("R9", "port busy again l1_wr_valid", 64'(l1_wr_valid), 64'd0);
    @(negedge clk);
    #1;
    chk("R9", "third entry held", {l1_wr_addr, l1_wr_data, l1_wr_mask},
        {30'h702, 32'hD2D2D2D2, 4'h8});
    l1_wr_free = 1'b1;
    #1;
    chk("R9", "third write valid", 64'(l1_wr_valid), 64'd1);
    @(negedge clk);
    #1;
    chk("R9", "drained empty l1_wr_valid", 64'(l1_wr_valid), 64'd0);

    // R10: full checker-side ring
    @(negedge clk);
    l1_wr_free = 1'b0;
    for (int k = 0; k < 8; k++) ver_put(30'h500 + 30'(k), 32'hE0000000 + 32'(k), 4'hF);
    ver_st_valid = 1'b1; ver_st_addr = 30'h5FF; ver_st_data = 32'hFFFFFFFF; ver_st_mask = 4'hF;
    #1;
    chk("R10", "full and busy ver_st_ready", 64'(ver_st_ready), 64'd0);
    @(negedge clk);
    l1_wr_free = 1'b1; ver_st_addr = 30'h508; ver_st_data = 32'hE0000008;
    #1;
    chk("R10", "full and write ver_st_ready", 64'(ver_st_ready), 64'd1);
    chk("R10", "head during swap", 64'(l1_wr_addr), 64'h500);
    @(negedge clk);
    ver_st_valid = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      #1;
      chk("R10", $sformatf("drain %0d valid", k), 64'(l1_wr_valid), 64'd1);
      chk("R10", $sformatf("drain %0d entry", k), {l1_wr_addr, l1_wr_data},
          {30'h500 + 30'(k), 32'hE0000000 + 32'(k)});
      @(negedge clk);
    end
    #1;
    chk("R10", "dropped store never written", 64'(l1_wr_valid), 64'd0);

    finished = 1'b1;
    report();
    $finish;
  end
endmodule